// File: doc/BRIEF.md
# GPIO Port Configuration Register Block

This block is the register front end of one general-purpose I/O port with up to sixteen pins. Software reaches it over a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). Each pin has a 2-bit mode (input, output, alternate function, analog), a 1-bit output driver type, a 2-bit drive-speed code, a 2-bit pull selection and a 4-bit alternate-function index. An output data latch drives the pin values. It can be written in full, or changed atomically through a write-only set/clear register, so software never needs a read-modify-write.

The block turns the stored fields into per-pin control lines for the pad ring: output enable, output value, open-drain flag, pull code, speed code, analog flag and function index. The external pin levels pass through a two-stage synchronizer before software can read them back.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every stored field is zero: all pins are inputs, floating, push-pull, low speed, function 0, and the output latch is 0. Every register reads 0 and `pin_oe` is 0.
- R2: The mode register (byte offset 0x00) gives pin n the bits [2n+1:2n], coded 0 input, 1 output, 2 alternate function, 3 analog. It reads back as written. `pin_oe[n]` is 1 exactly for codes 1 and 2, and `pin_analog[n]` is 1 exactly for code 3.
- R3: The driver-type register (0x04) holds one bit per pin, 0 push-pull and 1 open-drain. It drives `pin_od` and reads back in bits [15:0], with the upper bits 0.
- R4: The speed register (0x08, codes 0 low to 3 very high) and the pull register (0x0C, 0 floating, 1 pull-up, 2 pull-down, 3 reserved) use bits [2n+1:2n] for pin n. They read back as written, and `pin_speed`/`pin_pull` carry them unchanged, including the reserved code 3.
- R5: The input register (0x10) returns the pin levels in bits [15:0], with bits [31:16] 0. A level change on `pin_in` becomes visible on the second rising clock edge after it, and not on the first.
- R6: A write to the output register (0x14) loads bits [15:0] into the output latch and ignores bits [31:16]. Reads return the latch, with the upper bits 0. `pin_out` equals the latch. The latch changes only on writes to 0x14 or 0x18.
- R7: A write to the set/clear register (0x18) with bit n (n < 16) at 1 drives latch bit n to 1. Bits written as 0 leave the latch unchanged.
- R8: A write to 0x18 with bit n+16 at 1 clears latch bit n, unless bit n of the same write is also 1.
- R9: When one write to 0x18 has both the set bit and the clear bit of a pin at 1, the set wins and the pin ends at 1.
- R10: The set/clear register at 0x18 always reads 0.
- R11: The function index of pin n sits at bits [4(n mod 8)+3 : 4(n mod 8)] of the low function register (0x20) for pins 0-7, and of the high function register (0x24) for pins 8-15. Both registers read back as written, and `pin_af[4n+3:4n]` carries the index of pin n.
- R12: Writes to 0x1C and to any other unmapped word address change no stored field and no pin output. Such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits [1:0] are ignored |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pad input levels |
| pin_oe | output | 16 | Output driver enable per pin |
| pin_out | output | 16 | Output latch value per pin |
| pin_od | output | 16 | Open-drain select per pin |
| pin_pull | output | 32 | Pull code, 2 bits per pin |
| pin_speed | output | 32 | Speed code, 2 bits per pin |
| pin_analog | output | 16 | Analog mode flag per pin |
| pin_af | output | 64 | Alternate-function index, 4 bits per pin |

## Verification
The bench goes after the set/clear register. It writes set and clear bits for the same pin, where a design that let the clear win would leave the pin low. It writes mixed patterns, where a design that merged them wrongly would disturb pins whose bits were zero. It tests the function-index boundary at pins 7/8 and 15, where an off-by-one split would put a pin's index in the wrong register or at the wrong nibble. It counts the synchronizer latency edge by edge, so a one-stage or three-stage path shows up. It writes the output register with all upper bits at 1, and writes the unused lock offset, where a design with leaking storage would change the read-back or the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // byte offsets of the stored registers
   localparam int OFS_MODE  = 'h00;
   localparam int OFS_OTYPE = 'h04;
   localparam int OFS_SPEED = 'h08;
   localparam int OFS_PULL  = 'h0C;
   localparam int OFS_IDATA = 'h10;
   localparam int OFS_ODATA = 'h14;
   localparam int OFS_SETCL = 'h18;
   localparam int OFS_AFLO  = 'h20;
   localparam int OFS_AFHI  = 'h24;

   // half-word position of the clear field in the set/clear register
   localparam int CLR_BASE  = 16;

   typedef enum logic [1:0] {
      PM_INPUT  = 2'd0,
      PM_OUTPUT = 2'd1,
      PM_ALTFN  = 2'd2,
      PM_ANALOG = 2'd3
   } pin_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_odr_update.sv
module gpio_odr_update #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_val,
   input  logic             setcl_en,
   input  logic [WIDTH-1:0] set_bits,
   input  logic [WIDTH-1:0] clr_bits,
   output logic [WIDTH-1:0] nxt
);

   // clear first, then set: a pin with both bits ends high
   always_comb begin
      if (load_en)       nxt = load_val;
      else if (setcl_en) nxt = (cur & ~clr_bits) | set_bits;
      else               nxt = cur;
   end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
   import gpio_port_pkg::*;
(
   input  logic [1:0] mode,
   output logic       oe,
   output logic       analog
);

   pin_mode_e m;
   assign m      = pin_mode_e'(mode);
   assign oe     = (m == PM_OUTPUT) || (m == PM_ALTFN);
   assign analog = (m == PM_ANALOG);

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_od,
   output logic [2*NUM_PINS-1:0] pin_pull,
   output logic [2*NUM_PINS-1:0] pin_speed,
   output logic [NUM_PINS-1:0]   pin_analog,
   output logic [4*NUM_PINS-1:0] pin_af
);

   localparam int FW2     = 2 * NUM_PINS;
   localparam int FW4     = 4 * NUM_PINS;
   localparam int WORD_AW = ADDR_W - 2;
   localparam int AF_PER  = 8;

   generate
      if (NUM_PINS < 1 || NUM_PINS > CLR_BASE) begin : g_bad_pins
         $error("gpio_port_regs: NUM_PINS must be 1..16");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("gpio_port_regs: ADDR_W must cover offset 0x24");
      end
   endgenerate

   localparam logic [WORD_AW-1:0] W_MODE  = WORD_AW'(OFS_MODE  / 4);
   localparam logic [WORD_AW-1:0] W_OTYPE = WORD_AW'(OFS_OTYPE / 4);
   localparam logic [WORD_AW-1:0] W_SPEED = WORD_AW'(OFS_SPEED / 4);
   localparam logic [WORD_AW-1:0] W_PULL  = WORD_AW'(OFS_PULL  / 4);
   localparam logic [WORD_AW-1:0] W_IDATA = WORD_AW'(OFS_IDATA / 4);
   localparam logic [WORD_AW-1:0] W_ODATA = WORD_AW'(OFS_ODATA / 4);
   localparam logic [WORD_AW-1:0] W_SETCL = WORD_AW'(OFS_SETCL / 4);
   localparam logic [WORD_AW-1:0] W_AFLO  = WORD_AW'(OFS_AFLO  / 4);
   localparam logic [WORD_AW-1:0] W_AFHI  = WORD_AW'(OFS_AFHI  / 4);

   logic [WORD_AW-1:0] widx;
   logic               unused_addr_lsb;
   assign widx            = bus_addr[ADDR_W-1:2];
   assign unused_addr_lsb = ^bus_addr[1:0];

   logic sel_mode, sel_otype, sel_speed, sel_pull, sel_odata, sel_setcl, sel_aflo, sel_afhi;
   assign sel_mode  = (widx == W_MODE);
   assign sel_otype = (widx == W_OTYPE);
   assign sel_speed = (widx == W_SPEED);
   assign sel_pull  = (widx == W_PULL);
   assign sel_odata = (widx == W_ODATA);
   assign sel_setcl = (widx == W_SETCL);
   assign sel_aflo  = (widx == W_AFLO);
   assign sel_afhi  = (widx == W_AFHI);

   logic [FW2-1:0]      mode_q, speed_q, pull_q;
   logic [NUM_PINS-1:0] otype_q, odata_q, odata_d, idata_s;
   logic [FW4-1:0]      af_q;

   gpio_odr_update #(.WIDTH(NUM_PINS)) u_odr (
      .cur      (odata_q),
      .load_en  (bus_we && sel_odata),
      .load_val (bus_wdata[NUM_PINS-1:0]),
      .setcl_en (bus_we && sel_setcl),
      .set_bits (bus_wdata[NUM_PINS-1:0]),
      .clr_bits (bus_wdata[CLR_BASE +: NUM_PINS]),
      .nxt      (odata_d)
   );

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (idata_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         otype_q <= '0;
         speed_q <= '0;
         pull_q  <= '0;
         odata_q <= '0;
         af_q    <= '0;
      end else begin
         odata_q <= odata_d;
         if (bus_we) begin
            if (sel_mode)  mode_q  <= bus_wdata[FW2-1:0];
            if (sel_otype) otype_q <= bus_wdata[NUM_PINS-1:0];
            if (sel_speed) speed_q <= bus_wdata[FW2-1:0];
            if (sel_pull)  pull_q  <= bus_wdata[FW2-1:0];
            for (int n = 0; n < NUM_PINS; n++) begin
               if ((n < AF_PER) ? sel_aflo : sel_afhi)
                  af_q[4*n +: 4] <= bus_wdata[4*(n % AF_PER) +: 4];
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (widx)
         W_MODE:  bus_rdata[FW2-1:0]      = mode_q;
         W_OTYPE: bus_rdata[NUM_PINS-1:0] = otype_q;
         W_SPEED: bus_rdata[FW2-1:0]      = speed_q;
         W_PULL:  bus_rdata[FW2-1:0]      = pull_q;
         W_IDATA: bus_rdata[NUM_PINS-1:0] = idata_s;
         W_ODATA: bus_rdata[NUM_PINS-1:0] = odata_q;
         W_AFLO, W_AFHI: begin
            for (int n = 0; n < NUM_PINS; n++) begin
               if ((n < AF_PER) == (widx == W_AFLO))
                  bus_rdata[4*(n % AF_PER) +: 4] = af_q[4*n +: 4];
            end
         end
         default: bus_rdata = '0;
      endcase
   end

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pin_drive u_drv (
            .mode   (mode_q[2*p +: 2]),
            .oe     (pin_oe[p]),
            .analog (pin_analog[p])
         );
      end
   endgenerate

   assign pin_out   = odata_q;
   assign pin_od    = otype_q;
   assign pin_pull  = pull_q;
   assign pin_speed = speed_q;
   assign pin_af    = af_q;

   logic wr_unmapped;
   assign wr_unmapped = bus_we && !(sel_mode || sel_otype || sel_speed || sel_pull ||
                                    sel_odata || sel_setcl || sel_aflo || sel_afhi);

   // R7
   setcl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_setcl) |=>
      ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

   // R8
   setcl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_setcl) |=>
      ((pin_out & $past(bus_wdata[CLR_BASE +: NUM_PINS]) &
        ~$past(bus_wdata[NUM_PINS-1:0])) == '0));

   // R6
   odata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && (sel_odata || sel_setcl)) |=> $stable(pin_out));

   // R10
   setcl_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_setcl |-> (bus_rdata == 32'd0));

   // R12
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_unmapped |=> $stable({pin_oe, pin_out, pin_od, pin_pull, pin_speed, pin_analog, pin_af}));

endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [5:0]    bus_addr;
   logic          bus_we;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pin_in;
   logic [N-1:0]  pin_oe, pin_out, pin_od, pin_analog;
   logic [2*N-1:0] pin_pull, pin_speed;
   logic [4*N-1:0] pin_af;

   always #10 clk = ~clk;

   gpio_port_regs i_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_od(pin_od), .pin_pull(pin_pull),
      .pin_speed(pin_speed), .pin_analog(pin_analog), .pin_af(pin_af)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
   logic [15:0] m_otype, m_odr, m_idr;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      case (a[5:2])
         4'd0: return m_mode;
         4'd1: return {16'h0, m_otype};
         4'd2: return m_speed;
         4'd3: return m_pull;
         4'd4: return {16'h0, m_idr};
         4'd5: return {16'h0, m_odr};
         4'd8: return m_aflo;
         4'd9: return m_afhi;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] a);
      case (a[5:2])
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2, 4'd3: return "R4";
         4'd4: return "R5";
         4'd5: return "R6";
         4'd6: return "R10";
         4'd8, 4'd9: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic model_wr(input logic [5:0] a, input logic [31:0] d);
      case (a[5:2])
         4'd0: m_mode  = d;
         4'd1: m_otype = d[15:0];
         4'd2: m_speed = d;
         4'd3: m_pull  = d;
         4'd5: m_odr   = d[15:0];
         4'd6: m_odr   = (m_odr & ~d[31:16]) | d[15:0];
         4'd8: m_aflo  = d;
         4'd9: m_afhi  = d;
         default: ;
      endcase
   endtask

   task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd_chk(input logic [5:0] a);
      bus_addr = a;
      #1;
      chk(tag_of(a), bus_rdata, exp_rd(a));
   endtask

   task automatic chk_regs();
      for (int w = 0; w < 16; w++) rd_chk(6'(w * 4));
   endtask

   task automatic chk_pins();
      logic [15:0] eo, ea;
      for (int n = 0; n < N; n++) begin
         eo[n] = (m_mode[2*n +: 2] == 2'd1) || (m_mode[2*n +: 2] == 2'd2);
         ea[n] = (m_mode[2*n +: 2] == 2'd3);
      end
      chk("R2 oe", {16'h0, pin_oe}, {16'h0, eo});
      chk("R2 analog", {16'h0, pin_analog}, {16'h0, ea});
      chk("R6 out", {16'h0, pin_out}, {16'h0, m_odr});
      chk("R3 od", {16'h0, pin_od}, {16'h0, m_otype});
      chk("R4 speed", pin_speed, m_speed);
      chk("R4 pull", pin_pull, m_pull);
      chk("R11 af lo", pin_af[31:0], m_aflo);
      chk("R11 af hi", pin_af[63:32], m_afhi);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
      m_mode = '0; m_speed = '0; m_pull = '0; m_aflo = '0; m_afhi = '0;
      m_otype = '0; m_odr = '0; m_idr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 oe", {16'h0, pin_oe}, 32'h0);
      chk("R1 af", pin_af[31:0] | pin_af[63:32], 32'h0);
      chk_regs();
      chk_pins();

      // R5 synchronizer latency, edge by edge
      bus_addr = 6'h10;
      pin_in = 16'hA5C3;
      @(posedge clk); #1;
      chk("R5 one edge", bus_rdata, 32'h0);
      @(posedge clk); #1;
      chk("R5 two edges", bus_rdata, 32'h0000_A5C3);
      m_idr = 16'hA5C3;
      @(negedge clk);

      // R2 modes, including analog and alternate
      bus_wr(6'h00, 32'hE4E4_1B1B);
      chk_regs(); chk_pins();

      // R6 upper write bits ignored
      bus_wr(6'h14, 32'hFFFF_00F0);
      rd_chk(6'h14);
      chk("R6 upper", {16'h0, pin_out}, 32'h0000_00F0);

      // R7 set, R8 clear, zero bits untouched
      bus_wr(6'h18, 32'h00F0_0F00);
      chk("R7 R8 merge", {16'h0, pin_out}, 32'h0000_0F00);
      // R9 set wins on both
      bus_wr(6'h18, 32'h0003_0001);
      chk("R9 both", {16'h0, pin_out}, 32'h0000_0F01);
      // R10 reads zero
      bus_addr = 6'h18; #1;
      chk("R10 read", bus_rdata, 32'h0);

      // R11 boundary pins 7, 8, 15
      bus_wr(6'h20, 32'hA000_0003);
      bus_wr(6'h24, 32'hC000_000B);
      chk("R11 pin7", {28'h0, pin_af[31:28]}, 32'hA);
      chk("R11 pin8", {28'h0, pin_af[35:32]}, 32'hB);
      chk("R11 pin15", {28'h0, pin_af[63:60]}, 32'hC);
      chk("R11 pin0", {28'h0, pin_af[3:0]}, 32'h3);

      // R4 reserved pull code stored as written
      bus_wr(6'h0C, 32'hFFFF_FFFF);
      bus_wr(6'h08, 32'h1234_5678);
      chk_regs(); chk_pins();

      // R12 lock offset and an unmapped word
      bus_wr(6'h1C, 32'hFFFF_FFFF);
      bus_wr(6'h3C, 32'h5A5A_5A5A);
      chk_regs(); chk_pins();

      // random mix with a bias toward the set/clear register
      for (int it = 0; it < 600; it++) begin
         logic [5:0] a;
         logic [31:0] d;
         a = ($urandom % 4 == 0) ? 6'h18 : 6'(($urandom % 16) * 4);
         d = $urandom;
         if ($urandom % 5 != 0) bus_wr(a, d);
         else @(negedge clk);
         rd_chk(a);
         chk_pins();
         if (it % 40 == 39) begin
            pin_in = 16'($urandom);
            repeat (3) @(negedge clk);
            m_idr = pin_in;
            rd_chk(6'h10);
         end
      end
      chk_regs();

      report();
      $finish;
   end

endmodule